// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO with Fill Gauges

This block carries data words from a producer clocked by one clock to a consumer clocked by a second clock that has no relation to the first. The producer offers a word with `put` and must hold off while `full` is high. On the consumer side the oldest stored word is already on `dout` whenever `valid` is high. The consumer takes that word by raising `got` for one read-clock cycle, and the next word then falls through.

Each side also has a coarse gauge. On the read side, `fill_lvl` is a lower bound on how many words are stored. On the write side, `free_lvl` is a lower bound on how many more words can be written. Each gauge is the quantized result of subtracting a local binary pointer from the other side's pointer. That pointer crosses the clock boundary in Gray code through a two-flop synchronizer and is then converted back to binary. Because the far pointer arrives late, both gauges may read low but never read high. The storage depth is `MIN_DEPTH` rounded up to a power of two. Each gauge has `2^BITS` steps of `DEPTH/2^BITS` words. Setting a gauge's width parameter to 0 removes that gauge, and its port becomes a single bit tied to 0. Setting `OUT_REG` to 1 adds an output register that keeps the fall-through behaviour.

Top module: `afifo_gauge`

## Requirements
- R1: Words leave in the order they were written. Whenever `valid` is high, `dout` shows the oldest unread word. While `got` stays low, both `valid` and `dout` hold their values.
- R2: A read-clock cycle with `got` and `valid` both high removes exactly one word. No word is removed while `got` is low.
- R3: With the default `MIN_DEPTH` of 12, the storage depth is 16. `full` goes high once 16 words are stored and not yet read. A `put` while `full` is high stores nothing.
- R4: A `got` while `valid` is low has no effect. The next word written is the next word read.
- R5: `fill_lvl` equals floor(n * 2^FILL_BITS / DEPTH), limited to 2^FILL_BITS-1, where n is the read side's synchronized count of stored words. With the defaults, 8 stored words give 2, 12 give 3, 16 give 3, and fewer than 4 give 0. The value never exceeds what the true count justifies.
- R6: `free_lvl` equals floor(f * 2^FREE_BITS / DEPTH), limited to 2^FREE_BITS-1, where f is the write side's count of free entries. With the defaults, 8 stored words give 2, 12 give 1, and 16 give 0. `free_lvl` is 0 whenever `full` is high.
- R7: While held in reset, and just after release, the read side shows `valid` = 0 and `fill_lvl` = 0. The write side shows `full` = 0 and `free_lvl` at its maximum value (3 with the defaults).
- R8: The two resets may overlap in time. Once both have been applied and released, the FIFO is empty, whatever it held before, and it then carries new words correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wr | input | 1 | Write-side clock |
| rst_wr | input | 1 | Synchronous active-high reset, write side |
| put | input | 1 | Store `din` on this write clock edge |
| din | input | DATA_W | Word to store |
| full | output | 1 | No free entry as seen from the write side |
| free_lvl | output | max(FREE_BITS,1) | Quantized lower bound on free entries |
| clk_rd | input | 1 | Read-side clock |
| rst_rd | input | 1 | Synchronous active-high reset, read side |
| got | input | 1 | Consumer has taken the word on `dout` |
| valid | output | 1 | `dout` holds a stored word |
| dout | output | DATA_W | Oldest unread word (fall-through) |
| fill_lvl | output | max(FILL_BITS,1) | Quantized lower bound on stored words |

## Verification
The checker assumes that a reset which is not overlapping only ever starts from the read side: the read reset is raised first and released last. Under that order, the read-domain properties never see the write pointer jump backwards while they are enabled. The bench follows this order in its mid-run reset and otherwise drives `put` and `got` only on the falling edges of their own clocks, so the inputs are stable at every sampling edge. While `full` is high, the bench only ever tries the one deliberately rejected write. It raises `got` only when it intends to consume a word, apart from the deliberate pulses while `valid` is low.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  // Binary to reflected Gray code, evaluated on a 32-bit container
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Reflected Gray code back to binary
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/afifo_sync.sv
// Two-flop synchronizer for a Gray-coded pointer
module afifo_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/afifo_mem.sv
// Simple dual-port storage: writes on the write clock, reads by address
module afifo_mem #(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_wr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_wr) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/afifo_level.sv
// Quantizes a word count into BITS bits of depth fraction, saturating
module afifo_level #(
  parameter int CW   = 5,
  parameter int AW   = 4,
  parameter int BITS = 2,
  localparam int LW  = (BITS > 0) ? BITS : 1
) (
  input  logic [CW-1:0] amount,
  output logic [LW-1:0] lvl
);
  generate
    if (BITS == 0) begin : g_off
      assign lvl = '0;
    end else begin : g_on
      localparam int SH = AW - BITS;
      localparam logic [CW-1:0] MAXV = CW'((1 << BITS) - 1);
      logic [CW-1:0] steps;
      assign steps = amount >> SH;
      assign lvl   = (steps > MAXV) ? MAXV[LW-1:0] : steps[LW-1:0];
    end
  endgenerate
endmodule

// File: rtl/afifo_gauge.sv
module afifo_gauge #(
  parameter int DATA_W    = 8,
  parameter int MIN_DEPTH = 12,
  parameter int OUT_REG   = 0,
  parameter int FREE_BITS = 2,
  parameter int FILL_BITS = 2
) (
  input  logic                                 clk_wr,
  input  logic                                 rst_wr,
  input  logic                                 put,
  input  logic [DATA_W-1:0]                    din,
  output logic                                 full,
  output logic [((FREE_BITS>0)?FREE_BITS:1)-1:0] free_lvl,
  input  logic                                 clk_rd,
  input  logic                                 rst_rd,
  input  logic                                 got,
  output logic                                 valid,
  output logic [DATA_W-1:0]                    dout,
  output logic [((FILL_BITS>0)?FILL_BITS:1)-1:0] fill_lvl
);
  import afifo_pkg::*;

  localparam int AW    = (MIN_DEPTH < 2) ? 1 : $clog2(MIN_DEPTH);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  // ---------------- write domain ----------------
  logic [PW-1:0] wbin, wgray, wbin_nx, rgray_s, rbin_s, wused, wfree;
  logic          wr_en;

  assign wr_en   = put & ~full;
  assign wbin_nx = wbin + PW'(1);

  always_ff @(posedge clk_wr) begin
    if (rst_wr) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_en) begin
      wbin  <= wbin_nx;
      wgray <= PW'(to_gray(32'(wbin_nx)));
    end
  end

  afifo_sync #(.W(PW)) u_sync_r2w (
    .clk(clk_wr), .rst(rst_wr), .d(rgray), .q(rgray_s)
  );

  assign rbin_s = PW'(from_gray(32'(rgray_s)));
  assign wused  = wbin - rbin_s;
  assign full   = (wused == DEPTH_P);
  assign wfree  = DEPTH_P - wused;

  afifo_level #(.CW(PW), .AW(AW), .BITS(FREE_BITS)) u_free_lvl (
    .amount(wfree), .lvl(free_lvl)
  );

  // ---------------- storage ----------------
  logic [DATA_W-1:0] mem_rdata;

  afifo_mem #(.DW(DATA_W), .AW(AW)) u_mem (
    .clk_wr(clk_wr),
    .we    (wr_en),
    .waddr (wbin[AW-1:0]),
    .wdata (din),
    .raddr (rbin[AW-1:0]),
    .rdata (mem_rdata)
  );

  // ---------------- read domain ----------------
  logic [PW-1:0] rbin, rgray, rbin_nx, wgray_s, wbin_s, rused;
  logic [PW:0]   rcount;
  logic          mem_avail, pop;

  afifo_sync #(.W(PW)) u_sync_w2r (
    .clk(clk_rd), .rst(rst_rd), .d(wgray), .q(wgray_s)
  );

  assign wbin_s    = PW'(from_gray(32'(wgray_s)));
  assign rused     = wbin_s - rbin;
  assign mem_avail = (rused != '0);
  assign rbin_nx   = rbin + PW'(1);

  always_ff @(posedge clk_rd) begin
    if (rst_rd) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (pop) begin
      rbin  <= rbin_nx;
      rgray <= PW'(to_gray(32'(rbin_nx)));
    end
  end

  generate
    if (OUT_REG == 0) begin : g_direct
      assign valid  = mem_avail;
      assign dout   = mem_rdata;
      assign pop    = got & mem_avail;
      assign rcount = {1'b0, rused};
    end else begin : g_staged
      logic              ovalid;
      logic [DATA_W-1:0] odata;
      assign pop = mem_avail & (~ovalid | got);
      always_ff @(posedge clk_rd) begin
        if (rst_rd) begin
          ovalid <= 1'b0;
          odata  <= '0;
        end else if (pop) begin
          ovalid <= 1'b1;
          odata  <= mem_rdata;
        end else if (got) begin
          ovalid <= 1'b0;
        end
      end
      assign valid  = ovalid;
      assign dout   = odata;
      assign rcount = {1'b0, rused} + {{PW{1'b0}}, ovalid};
    end
  endgenerate

  afifo_level #(.CW(PW+1), .AW(AW), .BITS(FILL_BITS)) u_fill_lvl (
    .amount(rcount), .lvl(fill_lvl)
  );
endmodule

// File: rtl/afifo_gauge_chk.sv
module afifo_gauge_chk #(
  parameter int DATA_W  = 8,
  parameter int PW      = 5,
  parameter int OUT_REG = 0,
  parameter int FREE_LW = 2,
  parameter int FILL_LW = 2
) (
  input logic               clk_wr,
  input logic               rst_wr,
  input logic               full,
  input logic [FREE_LW-1:0] free_lvl,
  input logic [PW-1:0]      wbin,
  input logic [PW-1:0]      wgray,
  input logic               clk_rd,
  input logic               rst_rd,
  input logic               got,
  input logic               valid,
  input logic [DATA_W-1:0]  dout,
  input logic [FILL_LW-1:0] fill_lvl,
  input logic [PW-1:0]      rbin
);
  // R3
  full_block_chk: assert property (@(posedge clk_wr) disable iff (rst_wr)
    full |=> wbin == $past(wbin));

  // R3
  wgray_step_chk: assert property (@(posedge clk_wr) disable iff (rst_wr)
    $onehot0(wgray ^ $past(wgray)));

  // R6
  full_free_chk: assert property (@(posedge clk_wr) disable iff (rst_wr)
    full |-> free_lvl == '0);

  // R1
  hold_front_chk: assert property (@(posedge clk_rd) disable iff (rst_rd)
    valid && !got |=> valid && $stable(dout));

  generate
    if (OUT_REG == 0) begin : g_direct_chk
      // R4
      empty_pop_chk: assert property (@(posedge clk_rd) disable iff (rst_rd)
        !valid |=> rbin == $past(rbin));

      // R5
      empty_fill_chk: assert property (@(posedge clk_rd) disable iff (rst_rd)
        !valid |-> fill_lvl == '0);
    end
  endgenerate
endmodule

bind afifo_gauge afifo_gauge_chk #(
  .DATA_W (DATA_W),
  .PW     (PW),
  .OUT_REG(OUT_REG),
  .FREE_LW((FREE_BITS > 0) ? FREE_BITS : 1),
  .FILL_LW((FILL_BITS > 0) ? FILL_BITS : 1)
) u_chk (
  .clk_wr  (clk_wr),
  .rst_wr  (rst_wr),
  .full    (full),
  .free_lvl(free_lvl),
  .wbin    (wbin),
  .wgray   (wgray),
  .clk_rd  (clk_rd),
  .rst_rd  (rst_rd),
  .got     (got),
  .valid   (valid),
  .dout    (dout),
  .fill_lvl(fill_lvl),
  .rbin    (rbin)
);

// File: tb/afifo_gauge_test.sv
module afifo_gauge_test;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DW = 8;

  logic          clk_wr = 1'b0, clk_rd = 1'b0;
  logic          rst_wr = 1'b1, rst_rd = 1'b1;
  logic          put = 1'b0, got = 1'b0;
  logic [DW-1:0] din = '0;
  logic          full, valid;
  logic [1:0]    free_lvl, fill_lvl;
  logic [DW-1:0] dout;

  int nchecks = 0;
  int nfail   = 0;
  bit drain   = 1'b0;
  bit poke    = 1'b0;
  logic [DW-1:0] expq [$];

  always #(CLK_PERIOD/2) clk_wr = ~clk_wr;
  always #(RD_PERIOD/2)  clk_rd = ~clk_rd;

  afifo_gauge #(.DATA_W(DW), .MIN_DEPTH(12), .OUT_REG(0),
                .FREE_BITS(2), .FILL_BITS(2)) uut (
    .clk_wr(clk_wr), .rst_wr(rst_wr), .put(put), .din(din), .full(full),
    .free_lvl(free_lvl), .clk_rd(clk_rd), .rst_rd(rst_rd), .got(got),
    .valid(valid), .dout(dout), .fill_lvl(fill_lvl)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: one word per two write cycles, expectation queued
  task automatic push(input logic [DW-1:0] d);
    @(negedge clk_wr);
    put = 1'b1;
    din = d;
    expq.push_back(d);
    @(negedge clk_wr);
    put = 1'b0;
  endtask

  task automatic rd_wait(input int n);
    repeat (n) @(negedge clk_rd);
  endtask

  task automatic wr_wait(input int n);
    repeat (n) @(negedge clk_wr);
  endtask

  task automatic wait_drained();
    for (int i = 0; i < 2000 && expq.size() != 0; i++) @(negedge clk_rd);
    rd_wait(6);
  endtask

  // monitor: compares the front word and pops it (R1, R2)
  always @(negedge clk_rd) begin
    got = 1'b0;
    if (drain && valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R3 unexpected word", int'(dout), -1);
      end else begin
        chk(dout == expq[0], "R1 front word", int'(dout), int'(expq[0]));
        void'(expq.pop_front());
        got = 1'b1;
      end
    end else if (poke && !valid) begin
      got = 1'b1;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end

  initial begin
    wr_wait(5);
    // R7: state during reset
    chk(valid == 1'b0, "R7 valid in reset", valid, 0);
    chk(full == 1'b0, "R7 full in reset", full, 0);
    rst_wr = 1'b0;
    rst_rd = 1'b0;
    rd_wait(2);
    chk(valid == 1'b0, "R7 valid after reset", valid, 0);
    chk(fill_lvl == 2'd0, "R7 fill after reset", fill_lvl, 0);
    wr_wait(1);
    chk(free_lvl == 2'd3, "R7 free after reset", free_lvl, 3);

    // R5 R6: gauges at 8, 12, 16 stored words
    for (int i = 0; i < 8; i++) push(DW'(8'h10 + i));
    rd_wait(8);
    chk(fill_lvl == 2'd2, "R5 fill at 8", fill_lvl, 2);
    chk(valid == 1'b1, "R1 valid with data", valid, 1);
    chk(free_lvl == 2'd2, "R6 free at 8", free_lvl, 2);
    for (int i = 8; i < 12; i++) push(DW'(8'h10 + i));
    rd_wait(8);
    chk(fill_lvl == 2'd3, "R5 fill at 12", fill_lvl, 3);
    chk(free_lvl == 2'd1, "R6 free at 12", free_lvl, 1);
    for (int i = 12; i < 16; i++) push(DW'(8'h10 + i));
    wr_wait(1);
    chk(full == 1'b1, "R3 full at 16", full, 1);
    chk(free_lvl == 2'd0, "R6 free at 16", free_lvl, 0);
    rd_wait(8);
    chk(fill_lvl == 2'd3, "R5 fill saturates", fill_lvl, 3);
    chk(dout == 8'h10, "R2 no pop without got", int'(dout), 16);

    // R3: rejected writes while full (not queued)
    @(negedge clk_wr);
    put = 1'b1;
    din = 8'hEE;
    wr_wait(3);
    put = 1'b0;
    chk(full == 1'b1, "R3 still full", full, 1);

    drain = 1'b1;
    wait_drained();
    chk(valid == 1'b0, "R3 extra word absent", valid, 0);
    chk(fill_lvl == 2'd0, "R5 fill empty", fill_lvl, 0);
    wr_wait(6);
    chk(free_lvl == 2'd3, "R6 free empty", free_lvl, 3);

    // R4: got pulses while empty, then one word
    drain = 1'b0;
    poke  = 1'b1;
    rd_wait(5);
    poke  = 1'b0;
    rd_wait(1);
    chk(valid == 1'b0, "R4 still empty", valid, 0);
    push(8'h5A);
    rd_wait(6);
    chk(valid == 1'b1 && dout == 8'h5A, "R4 next word", int'(dout), 90);
    drain = 1'b1;
    wait_drained();

    // R1 R2: concurrent streaming
    for (int i = 0; i < 40; i++) push(DW'(i * 7 + 3));
    wait_drained();
    chk(expq.size() == 0, "R2 stream drained", expq.size(), 0);

    // R8: overlapping resets with data inside
    drain = 1'b0;
    for (int i = 0; i < 5; i++) push(DW'(8'hA0 + i));
    rd_wait(6);
    @(negedge clk_rd);
    rst_rd = 1'b1;
    wr_wait(2);
    rst_wr = 1'b1;
    wr_wait(3);
    rst_wr = 1'b0;
    rd_wait(4);
    rst_rd = 1'b0;
    expq.delete();
    rd_wait(4);
    chk(valid == 1'b0, "R8 empty after resets", valid, 0);
    chk(fill_lvl == 2'd0, "R8 fill after resets", fill_lvl, 0);
    wr_wait(6);
    chk(full == 1'b0, "R8 not full", full, 0);
    chk(free_lvl == 2'd3, "R8 free after resets", free_lvl, 3);
    drain = 1'b1;
    for (int i = 0; i < 3; i++) push(DW'(8'hC0 + i));
    wait_drained();
    chk(expq.size() == 0, "R8 words after resets", expq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end
endmodule